// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

An in-order 32-bit processor core that splits each instruction across five stages: fetch, decode with register read, execute, memory access and writeback. It runs a compact integer subset: register-register ADD, SUB, XOR, OR and AND; their immediate forms ADDI, XORI, ORI and ANDI; word load and store; the conditional branches BEQ and BNE; the jump-and-link JAL; and a HALT instruction that stops the machine. Each stage is fed by a pipeline register that carries its own nop bit. A nop bit set in a pipeline register leaves the stage it feeds idle for that cycle.

Branch outcomes are settled in the decode stage. For that reason the operands that decode compares are forwarded straight into decode from the execute, memory and writeback stages. Fetch always steps the PC by four, which amounts to predicting every branch as not taken. A taken branch or a jump costs one bubble. A load whose result is consumed by the next instruction costs one stall. A separate hazard unit makes the stall and redirect decisions. Two counters, total cycles and retired instructions, expose the CPI of a program. Both counters freeze once HALT has left writeback.

Top module: `rvp_core`

## Requirements
- R1: Memory words are big-endian. `imem_rdata` and `dmem_rdata` carry the byte at the port address in bits 31:24 and the byte at address+3 in bits 7:0. A store places `dmem_wdata[31:24]` at `dmem_addr`.
- R2: R-type instructions (opcode 0110011) compute rd = rs1 op rs2. The op is set by funct3: 000 gives ADD, or SUB when funct7 is 0100000; 100 gives XOR; 110 gives OR; 111 gives AND.
- R3: I-type ALU instructions (opcode 0010011) combine rs1 with the sign-extended 12-bit immediate in bits 31:20. The same funct3 codes select ADDI, XORI, ORI and ANDI.
- R4: LW (opcode 0000011, funct3 000) loads the 32-bit word at rs1+sext(imm). SW (opcode 0100011, funct3 010) stores rs2 at rs1+sext(imm). The store immediate is split across bits 31:25 and 11:7.
- R5: Register 0 always reads as zero. Writes to register 0 have no effect.
- R6: BEQ (opcode 1100011, funct3 000) and BNE (funct3 001) are resolved in decode. A taken branch discards the instruction fetched behind it and adds exactly one cycle. A branch that is not taken adds no cycle.
- R7: JAL (opcode 1101111) writes PC+4 to rd and continues at PC+sext(J-immediate). It adds exactly one cycle.
- R8: Results are forwarded into decode without a stall, with one exception: a load followed directly by an instruction that reads its destination register costs exactly one stall cycle.
- R9: HALT (opcode 1111111) in decode stops fetch, so no instruction after it executes. `halted` rises the cycle after HALT leaves writeback and then stays high.
- R10: `cycle_count` counts clock cycles from reset release until `halted` rises. `retired_count` counts non-nop instructions leaving writeback, HALT included. Both stay constant once `halted` is high.
- R11: While `rst` is high, `halted`, both counters and `imem_addr` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Big-endian instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, big-endian |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Big-endian data word at `dmem_addr`, combinational |
| halted | output | 1 | High once HALT has left writeback |
| cycle_count | output | 32 | Cycles run since reset release |
| retired_count | output | 32 | Instructions retired through writeback |

## Verification
The bench aims at the hazard corners. A branch that compares a value produced in the cycle just before it would read a stale register if forwarding into decode were missing. A branch that depends on a load two instructions back would compare stale data if the load result were not forwarded from the memory stage. A load followed directly by its consumer would either produce a wrong value or lose a cycle if the stall were missing or doubled. A taken branch or a JAL that does not drop the wrongly fetched instruction would let that instruction write a register, and the cycle count would also be off. Writes to register 0, byte order in memory, and instructions placed after HALT are each checked, because a core that gets them wrong leaves a visibly different memory image.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_BR   = 7'b1100011;
  localparam logic [6:0] OPC_LD   = 7'b0000011;
  localparam logic [6:0] OPC_ST   = 7'b0100011;
  localparam logic [6:0] OPC_HALT = 7'b1111111;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_XOR, ALU_OR, ALU_AND} alu_op_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [RIDX_W-1:0] rd;
    logic use_rs1;
    logic use_rs2;
    logic wr_rd;
    logic is_load;
    logic is_store;
    logic is_branch;
    logic branch_ne;
    logic is_jal;
    logic is_halt;
    logic imm_as_b;
    logic [XLEN-1:0] imm;
    alu_op_e alu_op;
  } dec_t;

  typedef struct packed {
    logic nop;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr;
  } fd_reg_t;

  typedef struct packed {
    logic nop;
    alu_op_e op;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] sdata;
    logic [RIDX_W-1:0] rd;
    logic wr;
    logic ld;
    logic st;
    logic halt;
  } dx_reg_t;

  typedef struct packed {
    logic nop;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] sdata;
    logic [RIDX_W-1:0] rd;
    logic wr;
    logic ld;
    logic st;
    logic halt;
  } xm_reg_t;

  typedef struct packed {
    logic nop;
    logic [XLEN-1:0] val;
    logic [RIDX_W-1:0] rd;
    logic wr;
    logic halt;
  } mw_reg_t;

  function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [31:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_j(input logic [31:0] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic alu_op_e f3_to_op(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b100:  return ALU_XOR;
      3'b110:  return ALU_OR;
      3'b111:  return ALU_AND;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_fn(input alu_op_e op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_XOR: return a ^ b;
      ALU_OR:  return a | b;
      ALU_AND: return a & b;
      default: return a + b;
    endcase
  endfunction
endpackage

// File: rtl/rvp_decode.sv
module rvp_decode
  import rvp_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [2:0] f3;
  assign f3 = instr[14:12];

  always_comb begin
    dec        = '0;
    dec.rs1    = instr[19:15];
    dec.rs2    = instr[24:20];
    dec.rd     = instr[11:7];
    dec.alu_op = ALU_ADD;
    case (instr[6:0])
      OPC_REG: begin
        dec.use_rs1 = 1'b1;
        dec.use_rs2 = 1'b1;
        dec.wr_rd   = 1'b1;
        dec.alu_op  = f3_to_op(f3, instr[30]);
      end
      OPC_IMM: begin
        dec.use_rs1  = 1'b1;
        dec.wr_rd    = 1'b1;
        dec.imm      = imm_i(instr);
        dec.imm_as_b = 1'b1;
        dec.alu_op   = f3_to_op(f3, 1'b0);
      end
      OPC_LD: if (f3 == 3'b000) begin
        dec.use_rs1  = 1'b1;
        dec.wr_rd    = 1'b1;
        dec.is_load  = 1'b1;
        dec.imm      = imm_i(instr);
        dec.imm_as_b = 1'b1;
      end
      OPC_ST: if (f3 == 3'b010) begin
        dec.use_rs1  = 1'b1;
        dec.use_rs2  = 1'b1;
        dec.is_store = 1'b1;
        dec.imm      = imm_s(instr);
        dec.imm_as_b = 1'b1;
      end
      OPC_BR: if (f3[2:1] == 2'b00) begin
        dec.use_rs1   = 1'b1;
        dec.use_rs2   = 1'b1;
        dec.is_branch = 1'b1;
        dec.branch_ne = f3[0];
        dec.imm       = imm_b(instr);
      end
      OPC_JAL: begin
        dec.wr_rd  = 1'b1;
        dec.is_jal = 1'b1;
        dec.imm    = imm_j(instr);
      end
      OPC_HALT: dec.is_halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rvp_regfile.sv
module rvp_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [DW-1:0] rdata1,
  output logic [DW-1:0] rdata2
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
  assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];
endmodule

// File: rtl/rvp_hazard.sv
module rvp_hazard #(
  parameter int RW = 5
) (
  input  logic          id_valid,
  input  logic          use_rs1,
  input  logic          use_rs2,
  input  logic [RW-1:0] rs1,
  input  logic [RW-1:0] rs2,
  input  logic          is_halt,
  input  logic          take_flow,
  input  logic          ex_valid,
  input  logic          ex_is_load,
  input  logic [RW-1:0] ex_rd,
  output logic          stall,
  output logic          redirect,
  output logic          halt_hit
);
  logic load_pending;
  logic hit1, hit2;

  assign load_pending = ex_valid && ex_is_load && (ex_rd != '0);
  assign hit1         = use_rs1 && (rs1 == ex_rd);
  assign hit2         = use_rs2 && (rs2 == ex_rd);
  assign stall        = id_valid && load_pending && (hit1 || hit2);
  assign redirect     = id_valid && !stall && take_flow;
  assign halt_hit     = id_valid && !stall && is_halt;
endmodule

// File: rtl/rvp_core.sv
module rvp_core
  import rvp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          CNT_W    = 32,
  parameter int          NREG     = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [31:0]      imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [31:0]      dmem_addr,
  output logic [31:0]      dmem_wdata,
  output logic             dmem_we,
  input  logic [31:0]      dmem_rdata,
  output logic             halted,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retired_count
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic            fetch_off_q;
  fd_reg_t         id_q, id_d;
  dx_reg_t         ex_q, ex_d;
  xm_reg_t         mem_q, mem_d;
  mw_reg_t         wb_q, wb_d;
  logic            halted_q;
  logic [CNT_W-1:0] cyc_q, ret_q;

  dec_t dec;
  logic [XLEN-1:0] rf_a, rf_b, rs1_v, rs2_v, ex_res, mem_val, target;
  logic id_valid, take_flow;
  logic stall_evt, redirect_evt, halt_hit;
  logic id_bubble, ex_bubble;

  function automatic logic [XLEN-1:0] fwd(
    input logic [RIDX_W-1:0] rs,  input logic [XLEN-1:0] rf_v,
    input logic ex_en,  input logic [RIDX_W-1:0] ex_rd,  input logic [XLEN-1:0] ex_v,
    input logic mem_en, input logic [RIDX_W-1:0] mem_rd, input logic [XLEN-1:0] mem_v,
    input logic wb_en,  input logic [RIDX_W-1:0] wb_rd,  input logic [XLEN-1:0] wb_v);
    if (rs == '0)                      return '0;
    else if (ex_en  && ex_rd  == rs)   return ex_v;
    else if (mem_en && mem_rd == rs)   return mem_v;
    else if (wb_en  && wb_rd  == rs)   return wb_v;
    else                               return rf_v;
  endfunction

  rvp_decode u_dec (.instr(id_q.instr), .dec(dec));

  rvp_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .we(!wb_q.nop && wb_q.wr), .waddr(wb_q.rd), .wdata(wb_q.val),
    .raddr1(dec.rs1), .raddr2(dec.rs2), .rdata1(rf_a), .rdata2(rf_b)
  );

  assign id_valid = !id_q.nop;
  assign ex_res   = alu_fn(ex_q.op, ex_q.a, ex_q.b);
  assign mem_val  = mem_q.ld ? dmem_rdata : mem_q.res;

  always_comb begin
    rs1_v = fwd(dec.rs1, rf_a,
                !ex_q.nop && ex_q.wr && !ex_q.ld, ex_q.rd, ex_res,
                !mem_q.nop && mem_q.wr, mem_q.rd, mem_val,
                !wb_q.nop && wb_q.wr, wb_q.rd, wb_q.val);
    rs2_v = fwd(dec.rs2, rf_b,
                !ex_q.nop && ex_q.wr && !ex_q.ld, ex_q.rd, ex_res,
                !mem_q.nop && mem_q.wr, mem_q.rd, mem_val,
                !wb_q.nop && wb_q.wr, wb_q.rd, wb_q.val);
  end

  assign take_flow = dec.is_jal || (dec.is_branch && ((rs1_v == rs2_v) ^ dec.branch_ne));
  assign target    = id_q.pc + dec.imm;

  rvp_hazard #(.RW(RIDX_W)) u_hz (
    .id_valid(id_valid), .use_rs1(dec.use_rs1), .use_rs2(dec.use_rs2),
    .rs1(dec.rs1), .rs2(dec.rs2), .is_halt(dec.is_halt), .take_flow(take_flow),
    .ex_valid(!ex_q.nop), .ex_is_load(ex_q.ld), .ex_rd(ex_q.rd),
    .stall(stall_evt), .redirect(redirect_evt), .halt_hit(halt_hit)
  );

  // Fetch and the fetch/decode register
  always_comb begin
    pc_d = pc_q + 32'd4;
    if (stall_evt || halt_hit || fetch_off_q) pc_d = pc_q;
    else if (redirect_evt)                    pc_d = target;

    id_d = '{nop: 1'b0, pc: pc_q, instr: imem_rdata};
    if (stall_evt) id_d = id_q;
    else if (redirect_evt || halt_hit || fetch_off_q) begin
      id_d     = id_q;
      id_d.nop = 1'b1;
    end
  end

  // Decode to execute
  always_comb begin
    ex_d       = '0;
    ex_d.nop   = !id_valid || stall_evt;
    ex_d.op    = dec.alu_op;
    ex_d.a     = dec.is_jal ? id_q.pc : rs1_v;
    ex_d.b     = dec.is_jal ? 32'd4 : (dec.imm_as_b ? dec.imm : rs2_v);
    ex_d.sdata = rs2_v;
    ex_d.rd    = dec.rd;
    ex_d.wr    = dec.wr_rd;
    ex_d.ld    = dec.is_load;
    ex_d.st    = dec.is_store;
    ex_d.halt  = dec.is_halt;
  end

  // Execute to memory, memory to writeback
  always_comb begin
    mem_d = '{nop: ex_q.nop, res: ex_res, sdata: ex_q.sdata, rd: ex_q.rd,
              wr: ex_q.wr, ld: ex_q.ld, st: ex_q.st, halt: ex_q.halt};
    wb_d  = '{nop: mem_q.nop, val: mem_val, rd: mem_q.rd, wr: mem_q.wr, halt: mem_q.halt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RESET_PC;
      fetch_off_q <= 1'b0;
      id_q        <= '{nop: 1'b1, default: '0};
      ex_q        <= '{nop: 1'b1, op: ALU_ADD, default: '0};
      mem_q       <= '{nop: 1'b1, default: '0};
      wb_q        <= '{nop: 1'b1, default: '0};
      halted_q    <= 1'b0;
      cyc_q       <= '0;
      ret_q       <= '0;
    end else begin
      pc_q        <= pc_d;
      fetch_off_q <= fetch_off_q || halt_hit;
      id_q        <= id_d;
      ex_q        <= ex_d;
      mem_q       <= mem_d;
      wb_q        <= wb_d;
      halted_q    <= halted_q || (!wb_q.nop && wb_q.halt);
      if (!halted_q)               cyc_q <= cyc_q + CNT_W'(1);
      if (!halted_q && !wb_q.nop)  ret_q <= ret_q + CNT_W'(1);
    end
  end

  assign id_bubble     = id_q.nop;
  assign ex_bubble     = ex_q.nop;
  assign imem_addr     = pc_q;
  assign dmem_addr     = mem_q.res;
  assign dmem_wdata    = mem_q.sdata;
  assign dmem_we       = !mem_q.nop && mem_q.st;
  assign halted        = halted_q;
  assign cycle_count   = cyc_q;
  assign retired_count = ret_q;
endmodule

// File: rtl/rvp_core_chk.sv
module rvp_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             halted,
  input logic [31:0]      pc,
  input logic             stall_evt,
  input logic             redirect_evt,
  input logic             id_bubble,
  input logic             ex_bubble,
  input logic             dmem_we,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] retired_count
);
  // R9
  halted_sticky_chk: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
  // R9
  no_store_when_halted_chk: assert property (@(posedge clk) disable iff (rst) halted |-> !dmem_we);
  // R10
  counters_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(cycle_count) && $stable(retired_count)));
  // R10
  cycle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));
  // R8
  stall_holds_pc_chk: assert property (@(posedge clk) disable iff (rst) stall_evt |=> $stable(pc));
  // R8
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst) stall_evt |=> ex_bubble);
  // R6
  redirect_bubble_chk: assert property (@(posedge clk) disable iff (rst) redirect_evt |=> id_bubble);
  // R6
  stall_redirect_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stall_evt, redirect_evt}));
endmodule

bind rvp_core rvp_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .pc(pc_q),
  .stall_evt(stall_evt), .redirect_evt(redirect_evt),
  .id_bubble(id_bubble), .ex_bubble(ex_bubble), .dmem_we(dmem_we),
  .cycle_count(cycle_count), .retired_count(retired_count)
);

// File: tb/tb_rvp_core.sv
module tb_rvp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted;
  logic [31:0] cycle_count, retired_count;

  always #5 clk = ~clk;

  rvp_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .halted(halted),
    .cycle_count(cycle_count), .retired_count(retired_count)
  );

  logic [7:0]  imem_b [0:1023];
  logic [7:0]  dmem_b [0:1023];
  logic [7:0]  mmem   [0:1023];
  logic [31:0] mreg   [0:31];
  logic [31:0] prog   [0:255];
  int plen;
  int tests = 0, fails = 0, wd = 0;

  // R1: big-endian byte lanes
  always_comb begin
    imem_rdata = {imem_b[imem_addr[9:0]], imem_b[10'(imem_addr[9:0] + 1)],
                  imem_b[10'(imem_addr[9:0] + 2)], imem_b[10'(imem_addr[9:0] + 3)]};
    dmem_rdata = {dmem_b[dmem_addr[9:0]], dmem_b[10'(dmem_addr[9:0] + 1)],
                  dmem_b[10'(dmem_addr[9:0] + 2)], dmem_b[10'(dmem_addr[9:0] + 3)]};
  end

  always @(negedge clk) if (dmem_we) begin
    dmem_b[dmem_addr[9:0]]            <= dmem_wdata[31:24];
    dmem_b[10'(dmem_addr[9:0] + 1)]   <= dmem_wdata[23:16];
    dmem_b[10'(dmem_addr[9:0] + 2)]   <= dmem_wdata[15:8];
    dmem_b[10'(dmem_addr[9:0] + 3)]   <= dmem_wdata[7:0];
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R9 watchdog: actual=running expected=halted");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [6:0] O_I = 7'b0010011, O_L = 7'b0000011;

  function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(logic [6:0] op, int imm, int rs1, int f3, int rd);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_s(int imm, int rs2, int rs1);
    logic [11:0] m = 12'(imm);
    return {m[11:5], 5'(rs2), 5'(rs1), 3'b010, m[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(int f3, int rs1, int rs2, int imm);
    logic [12:0] m = 13'(imm);
    return {m[12], m[10:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:1], m[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(int rd, int imm);
    logic [20:0] m = 21'(imm);
    return {m[20], m[10:1], m[11], m[19:12], 5'(rd), 7'b1101111};
  endfunction
  localparam logic [31:0] HALT_W = 32'h0000007F;

  function automatic logic [31:0] rdw(input int a);
    return {dmem_b[a], dmem_b[a+1], dmem_b[a+2], dmem_b[a+3]};
  endfunction
  function automatic logic [31:0] mrdw(input int a);
    return {mmem[a], mmem[a+1], mmem[a+2], mmem[a+3]};
  endfunction
  function automatic logic [31:0] sx(input logic [31:0] w, input int lo, input int n);
    logic [31:0] v = w >> lo;
    logic [31:0] m = (32'd1 << n) - 1;
    v = v & m;
    if (v[n-1]) v = v | ~m;
    return v;
  endfunction

  task automatic poke(input int a, input logic [31:0] v);
    {dmem_b[a], dmem_b[a+1], dmem_b[a+2], dmem_b[a+3]} = v;
    {mmem[a], mmem[a+1], mmem[a+2], mmem[a+3]} = v;
  endtask

  // Independent ISA-level model with timing rules from R6, R7, R8
  task automatic model_run(output int n_exec, output int n_cyc);
    int pc = 0, stalls = 0, redir = 0, prev_ld = 0;
    bit done = 0;
    n_exec = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    for (int step = 0; step < 2000 && !done; step++) begin
      logic [31:0] w, a, b, v, ea;
      int rs1, rs2, rd, f3, npc;
      bit u1, u2;
      w = prog[pc / 4];
      rs1 = int'(w[19:15]); rs2 = int'(w[24:20]); rd = int'(w[11:7]); f3 = int'(w[14:12]);
      a = mreg[rs1]; b = mreg[rs2]; npc = pc + 4;
      u1 = (w[6:0] != 7'b1101111) && (w[6:0] != 7'b1111111);
      u2 = (w[6:0] == 7'b0110011) || (w[6:0] == 7'b1100011) || (w[6:0] == 7'b0100011);
      n_exec++;
      if (prev_ld != 0 && ((u1 && rs1 == prev_ld) || (u2 && rs2 == prev_ld))) stalls++;
      prev_ld = 0;
      case (w[6:0])
        7'b0110011, 7'b0010011: begin
          if (w[6:0] == 7'b0010011) b = sx(w, 20, 12);
          case (f3)
            0: v = (w[6:0] == 7'b0110011 && w[30]) ? a - b : a + b;
            4: v = a ^ b;
            6: v = a | b;
            default: v = a & b;
          endcase
          if (rd != 0) mreg[rd] = v;
        end
        7'b0000011: begin
          ea = a + sx(w, 20, 12);
          if (rd != 0) mreg[rd] = mrdw(int'(ea[9:0]));
          prev_ld = rd;
        end
        7'b0100011: begin
          ea = a + sx({w[31:25], w[11:7], 20'd0}, 20, 12);
          {mmem[ea[9:0]], mmem[ea[9:0]+1], mmem[ea[9:0]+2], mmem[ea[9:0]+3]} = b;
        end
        7'b1100011: if ((a == b) != w[12]) begin
          npc = pc + int'(sx({w[31], w[7], w[30:25], w[11:8], 1'b0}, 0, 13));
          redir++;
        end
        7'b1101111: begin
          if (rd != 0) mreg[rd] = pc + 4;
          npc = pc + int'(sx({w[31], w[19:12], w[20], w[30:21], 1'b0}, 0, 21));
          redir++;
        end
        default: done = 1;
      endcase
      pc = npc;
    end
    n_cyc = n_exec + 4 + stalls + redir;
  endtask

  task automatic run_and_compare(input string tag, output int n_cyc_exp);
    int n_exec;
    logic [31:0] c0, r0;
    for (int i = 0; i < 1024; i++) imem_b[i] = 8'h00;
    for (int i = 0; i < plen; i++) {imem_b[4*i], imem_b[4*i+1], imem_b[4*i+2], imem_b[4*i+3]} = prog[i];
    model_run(n_exec, n_cyc_exp);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R11
    check(!halted && cycle_count == 0 && retired_count == 0 && imem_addr == 0,
          "R11 reset state", {halted, cycle_count[14:0], imem_addr[15:0]}, 32'h0);
    rst = 1'b0;
    for (int k = 0; k < 4000 && !halted; k++) @(negedge clk);
    check(halted, {"R9 halt reached ", tag}, {31'd0, halted}, 32'd1);
    for (int a = 32'h100; a < 32'h280; a += 4)
      check(rdw(a) == mrdw(a), {"R4 memory image ", tag}, rdw(a), mrdw(a));
    check(retired_count == n_exec, {"R10 retired ", tag}, retired_count, n_exec);
    check(cycle_count == n_cyc_exp, {"R6 R8 R10 cycles ", tag}, cycle_count, n_cyc_exp);
    c0 = cycle_count; r0 = retired_count;
    repeat (5) @(negedge clk);
    check(halted && cycle_count == c0 && retired_count == r0,
          {"R10 frozen ", tag}, cycle_count, c0);
  endtask

  initial begin
    int nc;
    void'($urandom(32'd20240611));
    // ---------------- directed program ----------------
    for (int i = 0; i < 1024; i++) begin dmem_b[i] = 8'h00; mmem[i] = 8'h00; end
    poke(32'h104, 32'h11223344);
    poke(32'h108, 32'hDEADBEEF);
    poke(32'h118, 32'hCAFEF00D);
    plen = 0;
    prog[plen++] = e_i(O_I, -5, 0, 0, 1);
    prog[plen++] = e_i(O_I, 3, 0, 0, 2);
    prog[plen++] = e_r(32, 1, 2, 0, 3);       // SUB x3 = 8, forwarded from EX
    prog[plen++] = e_i(O_I, 7, 0, 0, 0);      // write to x0
    prog[plen++] = e_s(32'h100, 3, 0);
    prog[plen++] = e_i(O_L, 32'h104, 0, 0, 4);
    prog[plen++] = e_r(0, 0, 4, 0, 5);        // load-use
    prog[plen++] = e_b(0, 5, 4, 8);           // BEQ taken, operand from EX
    prog[plen++] = e_i(O_I, 1, 0, 0, 6);      // skipped
    prog[plen++] = e_b(1, 0, 0, 8);           // BNE not taken
    prog[plen++] = e_j(7, 8);                 // JAL x7 = 44
    prog[plen++] = e_i(O_I, 2, 0, 0, 6);      // skipped
    prog[plen++] = e_s(32'h108, 0, 0);
    prog[plen++] = e_s(32'h10C, 7, 0);
    prog[plen++] = e_s(32'h110, 5, 0);
    prog[plen++] = e_i(O_L, 32'h104, 0, 0, 8);
    prog[plen++] = e_i(O_I, 0, 0, 0, 9);
    prog[plen++] = e_b(0, 8, 4, 8);           // BEQ on load two back
    prog[plen++] = e_i(O_I, 9, 0, 0, 9);      // skipped
    prog[plen++] = e_s(32'h114, 9, 0);
    prog[plen++] = e_i(O_I, 240, 1, 4, 10);   // XORI
    prog[plen++] = e_i(O_I, -256, 2, 6, 11);  // ORI
    prog[plen++] = e_i(O_I, -2, 10, 7, 12);   // ANDI
    prog[plen++] = e_r(0, 11, 10, 4, 13);
    prog[plen++] = e_r(0, 11, 10, 6, 14);
    prog[plen++] = e_r(0, 11, 10, 7, 15);
    for (int r = 10; r <= 15; r++) prog[plen++] = e_s(32'h120 + 4 * (r - 10), r, 0);
    prog[plen++] = HALT_W;
    prog[plen++] = e_s(32'h118, 1, 0);        // after HALT
    prog[plen++] = e_i(O_I, 1, 0, 0, 1);
    run_and_compare("directed", nc);
    check(rdw(32'h100) == 32'd8, "R2 SUB result", rdw(32'h100), 32'd8);
    check(dmem_b[32'h100] == 8'h00 && dmem_b[32'h103] == 8'h08, "R1 store byte order",
          {dmem_b[32'h100], dmem_b[32'h103]}, 32'h0008);
    check(rdw(32'h110) == 32'h11223344, "R1 R8 load-use value", rdw(32'h110), 32'h11223344);
    check(rdw(32'h108) == 32'd0, "R5 x0 reads zero", rdw(32'h108), 32'd0);
    check(rdw(32'h10C) == 32'd44, "R7 link value", rdw(32'h10C), 32'd44);
    check(rdw(32'h114) == 32'd0, "R6 branch on forwarded load", rdw(32'h114), 32'd0);
    check(rdw(32'h118) == 32'hCAFEF00D, "R9 no execution after halt", rdw(32'h118), 32'hCAFEF00D);
    check(rdw(32'h120) == 32'hFFFFFF0B, "R3 XORI sign-extended", rdw(32'h120), 32'hFFFFFF0B);
    check(rdw(32'h124) == 32'hFFFFFF03, "R3 ORI negative imm", rdw(32'h124), 32'hFFFFFF03);
    check(cycle_count == 32'd38, "R6 R7 R8 directed cycle count", cycle_count, 32'd38);
    check(retired_count == 32'd30, "R10 directed retired", retired_count, 32'd30);

    // ---------------- constrained random programs ----------------
    for (int p = 0; p < 12; p++) begin
      for (int i = 0; i < 1024; i++) begin dmem_b[i] = 8'h00; mmem[i] = 8'h00; end
      for (int a = 32'h100; a < 32'h140; a += 4) poke(a, $urandom);
      plen = 0;
      for (int r = 1; r <= 7; r++) prog[plen++] = e_i(O_I, int'($urandom_range(0, 4095)), 0, 0, r);
      for (int i = 0; i < 48; i++) begin
        int k = int'($urandom_range(0, 11));
        int rd = int'($urandom_range(0, 7)), ra = int'($urandom_range(0, 7)), rb = int'($urandom_range(0, 7));
        int f3s[4] = '{0, 4, 6, 7};
        int f3 = f3s[$urandom_range(0, 3)];
        case (k)
          0, 1, 2: prog[plen++] = e_r((f3 == 0 && $urandom_range(0, 1) == 1) ? 32 : 0, rb, ra, f3, rd);
          3, 4:    prog[plen++] = e_i(O_I, int'($urandom_range(0, 4095)), ra, f3, rd);
          5, 6:    prog[plen++] = e_i(O_L, 32'h100 + 4 * int'($urandom_range(0, 15)), 0, 0, rd);
          7:       prog[plen++] = e_s(32'h100 + 4 * int'($urandom_range(0, 15)), rb, 0);
          8, 9:    prog[plen++] = e_b(int'($urandom_range(0, 1)), ra, rb, 4 * int'($urandom_range(2, 3)));
          default: prog[plen++] = e_j(rd, 8);
        endcase
      end
      for (int r = 1; r < 32; r++) prog[plen++] = e_s(32'h200 + 4 * r, r, 0);
      prog[plen++] = HALT_W;
      prog[plen++] = e_s(32'h200, 1, 0);
      run_and_compare($sformatf("random%0d", p), nc);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule